// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block is the slave side of a three-wire serial EEPROM: the command front end, the write-protection latch, the self-timed programming sequencer and a register-array model of the storage cells. A host selects the device with `cs`, clocks bits in on `di` with rising edges of `sclk`, and reads data or programming status on `dout`. The output has a separate enable, `dout_oe`, which models the high-impedance state of the pin.

The serial inputs are slow compared with the system clock `clk`. They pass through a synchroniser, and the block finds `sclk` rising edges by sampling. A frame is a start bit, a two-bit command code, an address and, for writes, a data word. The command set covers reading with address auto-increment, single-location write and erase, whole-array erase and fill, and enabling or disabling programming. Programming runs for a fixed number of system clocks and needs no `sclk` activity. The `org` input selects between bytes and 16-bit words.

Top module: `mw_eeprom`

## Requirements
- R1: The block stays idle until the first rising `sclk` edge at which `cs` and `di` are both high. Rising edges with `di` low, and any activity while `cs` is low, start nothing.
- R2: The start bit is followed by a 2-bit code, sent MSB first: 10 reads, 01 writes, 11 erases one location. Code 00 is an extended command, chosen by the first two address bits: 11 enables programming, 00 disables it, 10 erases the whole array, 01 fills the whole array.
- R3: A read drives one 0 on `dout` after the edge that carries the last address bit. Each later rising edge then shifts out one data bit, MSB first. After the last bit of a word, the next word follows without a dummy bit. The address wraps from the top location to 0.
- R4: After reset, programming is disabled. While it is disabled, write, erase, erase-all and fill-all start no programming cycle and leave the array unchanged.
- R5: A write stores the received word at the addressed location. An erase sets that location to all ones.
- R6: Erase-all sets every location to all ones. Fill-all clears the array to ones and then stores the received word in every location.
- R7: With `org` high, the array holds 2^(ABITS-1) 16-bit words and takes ABITS-1 address bits. With `org` low, it holds 2^ABITS bytes and takes ABITS address bits. 16-bit word n is made of byte 2n (bits 15:8) and byte 2n+1 (bits 7:0).
- R8: A programming cycle lasts PROG_CYCLES clocks and finishes even if `cs` falls. While `cs` is high and no frame is in progress, `dout` reports 0 while the cycle is busy and 1 once it is ready.
- R9: When `cs` is low, `dout_oe` is low and the command parser returns to idle. If `cs` stays low through a whole programming cycle, `dout_oe` stays low.
- R10: A start bit received after programming has finished, followed by `cs` going low, removes the ready status. After that, raising `cs` leaves `dout_oe` low.
- R11: Once a frame has received all of its bits, further `sclk` and `di` activity is ignored until `cs` goes low. Start bits received while programming is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| org | input | 1 | Word size select: 1 = 16-bit words, 0 = bytes |
| cs | input | 1 | Device select, active high |
| sclk | input | 1 | Serial bit clock |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out or ready/busy status |
| dout_oe | output | 1 | Drive enable for `dout`; low means high impedance |

## Verification
The bench builds the block with ABITS=7, which gives 128 bytes or 64 words, with PROG_CYCLES=40 and with SYNC_STAGES=2. At that size the bench can write every byte address one at a time and read the whole array back in a single sequential read that runs past the wrap point, in both word sizes. The 40-cycle programming window is long enough for a full start bit to arrive during the busy phase, which shows that such a start is ignored. It also makes the busy-to-ready transition on `dout` visible.

// File: rtl/mw_pkg.sv
// Shared types for the serial EEPROM command engine.
package mw_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_RD, ST_DONE} mw_state_e;
    typedef enum logic [1:0] {PG_WRITE, PG_ERASE, PG_ERAL, PG_WRAL} mw_prog_e;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;
    localparam logic [1:0] EXT_EN    = 2'b11;
    localparam logic [1:0] EXT_DIS   = 2'b00;
    localparam logic [1:0] EXT_CLR   = 2'b10;
    localparam logic [1:0] EXT_FILL  = 2'b01;
endpackage

// File: rtl/mw_sync.sv
// Multi-stage synchroniser for a group of slow inputs.
// Assumes the inputs change far less often than clk toggles; all bits share one delay.
module mw_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] st [STAGES];

    // First stage captures the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end

    genvar g;
    for (g = 1; g < STAGES; g++) begin : g_stage
        // Each further stage retimes the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= st[g-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
// Self-timed programming counter: busy for PROG_CYCLES clocks after start.
// done is high in the last busy cycle. Assumes start only arrives while idle.
module mw_prog_timer #(
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] ONE = 1;
    logic [CW-1:0] cnt;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(PROG_CYCLES);
        else if (cnt != '0)  cnt <= cnt - ONE;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == ONE);
endmodule

// File: rtl/mw_array.sv
// Byte-organised storage cells with whole-array and single-location updates.
// Storage has no reset: it models nonvolatile content. 16-bit word n maps to bytes 2n (high) and 2n+1 (low).
module mw_array import mw_pkg::*; #(
    parameter int ABITS = 9
) (
    input  logic             clk,
    input  logic             erase_all,
    input  logic             apply,
    input  mw_prog_e         op,
    input  logic             wr_org,
    input  logic [ABITS-1:0] wr_addr,
    input  logic [15:0]      wr_data,
    input  logic             rd_org,
    input  logic [ABITS-1:0] rd_addr,
    output logic [15:0]      rd_word
);
    localparam int DEPTH = 1 << ABITS;
    logic [7:0]  mem [DEPTH];
    logic [15:0] val;
    logic        all_op;

    // Erasing ops store all ones; whole-array ops hit every location.
    assign val    = (op == PG_ERASE || op == PG_ERAL) ? 16'hFFFF : wr_data;
    assign all_op = (op == PG_ERAL || op == PG_WRAL);

    // Update cells: erase stage of fill-all, then the completing operation.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (erase_all) begin
                mem[i] <= 8'hFF;
            end else if (apply) begin
                if (all_op || (wr_org ? (ABITS'(i / 2) == wr_addr) : (ABITS'(i) == wr_addr)))
                    mem[i] <= (wr_org && (i % 2 == 0)) ? val[15:8] : val[7:0];
            end
        end
    end

    assign rd_word = rd_org ? {mem[{rd_addr[ABITS-2:0], 1'b0}], mem[{rd_addr[ABITS-2:0], 1'b1}]}
                            : {8'h00, mem[rd_addr]};
endmodule

// File: rtl/mw_parser.sv
// Serial command parser: start detection, code/address/data shifting, command decode,
// programming-enable latch and read data shifter.
// Assumes cs/sclk/di are already synchronised to clk; the state is held idle while cs is low.
module mw_parser import mw_pkg::*; #(
    parameter int ABITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             sclk,
    input  logic             di,
    input  logic             org,
    input  logic             busy,
    input  logic [15:0]      rd_word,
    output logic [ABITS-1:0] rd_addr,
    output logic             start_det,
    output logic             rd_active,
    output logic             quiet,
    output logic             do_bit,
    output logic             wen,
    output logic             prog_start,
    output mw_prog_e         prog_op,
    output logic [ABITS-1:0] prog_addr,
    output logic [15:0]      prog_data
);
    localparam logic [ABITS-1:0] ONE_B = 1;
    localparam logic [ABITS-2:0] ONE_W = 1;

    mw_state_e        state;
    logic             sclk_d, rise, reload;
    logic [4:0]       cnt, bits_left, aw_m1, dw_m1;
    logic [1:0]       opc, top2;
    logic [ABITS-1:0] addr_sh, raw_addr, nxt_addr, inc_addr;
    logic [15:0]      dat_sh, nxt_dat, shreg;

    assign rise     = sclk & ~sclk_d;
    assign aw_m1    = org ? 5'(ABITS - 2) : 5'(ABITS - 1);
    assign dw_m1    = org ? 5'd15 : 5'd7;
    assign raw_addr = {addr_sh[ABITS-2:0], di};
    assign nxt_addr = org ? {1'b0, raw_addr[ABITS-2:0]} : raw_addr;
    assign top2     = org ? raw_addr[ABITS-2 -: 2] : raw_addr[ABITS-1 -: 2];
    assign nxt_dat  = {dat_sh[14:0], di};
    assign inc_addr = org ? {1'b0, rd_addr[ABITS-2:0] + ONE_W} : rd_addr + ONE_B;

    // Previous sclk level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk;
    end

    // Frame state machine, advanced once per sclk rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; cnt <= '0; opc <= '0; addr_sh <= '0; dat_sh <= '0;
            shreg <= '0; bits_left <= '0; reload <= 1'b0; do_bit <= 1'b0; rd_addr <= '0;
            wen <= 1'b0; start_det <= 1'b0; prog_start <= 1'b0; prog_op <= PG_WRITE;
            prog_addr <= '0; prog_data <= '0;
        end else begin
            start_det  <= 1'b0;
            prog_start <= 1'b0;
            if (reload) begin
                shreg  <= rd_word;
                reload <= 1'b0;
            end
            if (!cs) begin
                state <= ST_IDLE;
            end else if (rise) begin
                unique case (state)
                    ST_IDLE: if (di && !busy) begin
                        state <= ST_OPC; cnt <= '0; start_det <= 1'b1;
                    end
                    ST_OPC: begin
                        opc <= {opc[0], di};
                        cnt <= cnt + 5'd1;
                        if (cnt == 5'd1) begin state <= ST_ADR; cnt <= '0; end
                    end
                    ST_ADR: begin
                        addr_sh <= nxt_addr;
                        cnt     <= cnt + 5'd1;
                        if (cnt == aw_m1) begin
                            cnt   <= '0;
                            state <= ST_DONE;
                            if (opc == OPC_READ) begin
                                state <= ST_RD; rd_addr <= nxt_addr; reload <= 1'b1;
                                do_bit <= 1'b0; bits_left <= dw_m1 + 5'd1;
                            end else if (opc == OPC_WRITE) begin
                                state <= ST_DAT;
                            end else if (opc == OPC_ERASE) begin
                                prog_start <= wen; prog_op <= PG_ERASE; prog_addr <= nxt_addr;
                            end else if (top2 == EXT_EN) begin
                                wen <= 1'b1;
                            end else if (top2 == EXT_DIS) begin
                                wen <= 1'b0;
                            end else if (top2 == EXT_CLR) begin
                                prog_start <= wen; prog_op <= PG_ERAL;
                            end else begin
                                state <= ST_DAT;
                            end
                        end
                    end
                    ST_DAT: begin
                        dat_sh <= nxt_dat;
                        cnt    <= cnt + 5'd1;
                        if (cnt == dw_m1) begin
                            state      <= ST_DONE;
                            prog_start <= wen;
                            prog_op    <= (opc == OPC_WRITE) ? PG_WRITE : PG_WRAL;
                            prog_addr  <= addr_sh;
                            prog_data  <= nxt_dat;
                        end
                    end
                    ST_RD: begin
                        do_bit    <= org ? shreg[15] : shreg[7];
                        shreg     <= {shreg[14:0], 1'b0};
                        bits_left <= bits_left - 5'd1;
                        if (bits_left == 5'd1) begin
                            rd_addr   <= inc_addr;
                            reload    <= 1'b1;
                            bits_left <= dw_m1 + 5'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_active = (state == ST_RD);
    assign quiet     = (state == ST_IDLE) || (state == ST_DONE);
endmodule

// File: rtl/mw_eeprom.sv
// Top of the serial EEPROM command engine: synchroniser, parser, programming timer and array.
// Assumes org only changes while cs is low. dout_oe low models a high-impedance pin.
module mw_eeprom import mw_pkg::*; #(
    parameter int ABITS       = 9,
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org,
    input  logic cs,
    input  logic sclk,
    input  logic di,
    output logic dout,
    output logic dout_oe
);
    logic [2:0]       sync_q;
    logic             cs_s, sclk_s, di_s;
    logic             busy, done, stat;
    logic             start_det, rd_active, quiet, do_bit, wen, prog_start;
    mw_prog_e         prog_op, op_q;
    logic [ABITS-1:0] prog_addr, addr_q, rd_addr;
    logic [15:0]      prog_data, data_q, rd_word;
    logic             org_q;

    mw_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs, sclk, di}), .q(sync_q));
    assign {cs_s, sclk_s, di_s} = sync_q;

    mw_parser #(.ABITS(ABITS)) u_parser (
        .clk(clk), .rst_n(rst_n), .cs(cs_s), .sclk(sclk_s), .di(di_s), .org(org),
        .busy(busy), .rd_word(rd_word), .rd_addr(rd_addr), .start_det(start_det),
        .rd_active(rd_active), .quiet(quiet), .do_bit(do_bit), .wen(wen),
        .prog_start(prog_start), .prog_op(prog_op), .prog_addr(prog_addr), .prog_data(prog_data));

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .done(done));

    // Hold the programming operands for the whole self-timed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= PG_WRITE; addr_q <= '0; data_q <= '0; org_q <= 1'b0;
        end else if (prog_start) begin
            op_q <= prog_op; addr_q <= prog_addr; data_q <= prog_data; org_q <= org;
        end
    end

    // Ready/busy status stays pending from a programming start until the next start bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          stat <= 1'b0;
        else if (prog_start) stat <= 1'b1;
        else if (start_det)  stat <= 1'b0;
    end

    mw_array #(.ABITS(ABITS)) u_array (
        .clk(clk), .erase_all(prog_start && prog_op == PG_WRAL), .apply(done), .op(op_q),
        .wr_org(org_q), .wr_addr(addr_q), .wr_data(data_q),
        .rd_org(org), .rd_addr(rd_addr), .rd_word(rd_word));

    assign dout_oe = cs_s && (rd_active || (stat && quiet));
    assign dout    = rd_active ? do_bit : !busy;
endmodule

// File: rtl/mw_eeprom_chk.sv
// Property checker for mw_eeprom, attached by bind. Counts busy run length itself.
module mw_eeprom_chk #(
    parameter int PROG_CYCLES = 64
) (
    input logic clk,
    input logic rst_n,
    input logic prog_start,
    input logic busy,
    input logic wen,
    input logic rd_active,
    input logic dout,
    input logic dout_oe
);
    int unsigned run_len;

    // Length of the current busy run, in cycles before this one.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wen); // R4
    AST_PROG_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy); // R11
    AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy); // R8
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < PROG_CYCLES)); // R8
    AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_active) |-> (dout_oe && !dout)); // R3
    AST_READ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> !busy); // R11
endmodule

bind mw_eeprom mw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .busy(busy), .wen(wen),
    .rd_active(rd_active), .dout(dout), .dout_oe(dout_oe));

// File: tb/test_mw_eeprom.sv
// Self-checking bench: small array, exhaustive byte writes and full sequential sweeps.
module test_mw_eeprom;
    localparam int CLK_PERIOD = 10;
    localparam int ABITS = 7;
    localparam int PROG  = 40;
    localparam int HP    = 3;
    localparam int NBYTE = 1 << ABITS;

    logic clk = 1'b0, rst_n = 1'b0, org = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
    logic dout, dout_oe;
    logic last_do, last_oe;
    logic [7:0] model [NBYTE];
    int nchk = 0, nfail = 0;
    bit finished = 0;

    mw_eeprom #(.ABITS(ABITS), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) i_mw_eeprom (
        .clk(clk), .rst_n(rst_n), .org(org), .cs(cs), .sclk(sclk), .di(di),
        .dout(dout), .dout_oe(dout_oe));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int aw();
        return org ? ABITS - 1 : ABITS;
    endfunction

    function automatic int dw();
        return org ? 16 : 8;
    endfunction

    function automatic logic [15:0] ext(input logic [1:0] t);
        return 16'(t) << (aw() - 2);
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    task automatic bitx(input logic b);
        di = b; tick(HP); sclk = 1'b1; tick(HP); sclk = 1'b0; tick(HP);
        last_do = dout; last_oe = dout_oe;
    endtask

    task automatic send(input logic [15:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) bitx(v[k]);
    endtask

    task automatic cs_lo();
        cs = 1'b0; di = 1'b0; tick(4);
    endtask

    task automatic cs_hi();
        cs = 1'b1; tick(4);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [15:0] adr, input logic [15:0] dat, input bit wd);
        cs_hi(); bitx(1'b1); send(16'(op), 2); send(adr, aw());
        if (wd) send(dat, dw());
    endtask

    // Poll status after a programming command, then clear it with start + cs low.
    task automatic prog_wait(input string req);
        int n;
        cs_lo(); cs_hi();
        check({req, " busy status R8"}, {dout_oe, dout}, 2'b10);
        n = 0;
        while (!(dout_oe && dout) && n < 300) begin tick(1); n++; end
        check({req, " ready status R8"}, {dout_oe, dout}, 2'b11);
        bitx(1'b1); cs_lo();
    endtask

    task automatic read_start(input logic [15:0] adr, input string req);
        cmd(2'b10, adr, 16'h0, 0);
        check({req, " dummy zero R3"}, {last_oe, last_do}, 2'b10);
    endtask

    task automatic read_word(output logic [15:0] w);
        w = '0;
        for (int k = 0; k < dw(); k++) begin bitx(1'b0); w = {w[14:0], last_do}; end
    endtask

    initial begin
        logic [15:0] w;
        tick(5); rst_n = 1'b1; tick(3);
        check("R9 reset oe", dout_oe, 0);
        cs_hi();
        check("R9 no status after reset", dout_oe, 0);
        // R1: clocks with di low while selected, and with di high while deselected
        for (int k = 0; k < 10; k++) bitx(1'b0);
        check("R1 idle with di low", dout_oe, 0);
        cs_lo();
        for (int k = 0; k < 6; k++) bitx(1'b1);
        check("R1 idle with cs low", dout_oe, 0);

        // R4: erase-all before enabling programming starts nothing
        cmd(2'b00, ext(2'b10), 0, 0); cs_lo(); cs_hi();
        check("R4 erase-all ignored when disabled", dout_oe, 0);
        cs_lo();
        cmd(2'b00, ext(2'b11), 0, 0); cs_lo();                     // R2 enable
        cmd(2'b00, ext(2'b10), 0, 0); prog_wait("R6 erase-all");
        for (int a = 0; a < NBYTE; a++) model[a] = 8'hFF;

        // R6/R7: 16-bit sweep over erased array, every word all ones
        org = 1'b1;
        read_start(0, "R7 x16");
        for (int a = 0; a < NBYTE / 2; a++) begin
            read_word(w);
            check($sformatf("R6 erased word %0d", a), w, 16'hFFFF);
        end
        cs_lo();

        // R5: write every byte address in byte mode
        org = 1'b0;
        for (int a = 0; a < NBYTE; a++) begin
            cmd(2'b01, 16'(a), 16'(pat(a)), 1); prog_wait("R5 write");
            model[a] = pat(a);
        end
        // R3: one sequential read across the whole array and past the wrap
        read_start(0, "R3 x8");
        for (int a = 0; a <= NBYTE + 1; a++) begin
            read_word(w);
            check($sformatf("R3 seq byte %0d", a), w, 16'(model[a % NBYTE]));
        end
        cs_lo();
        read_start(16'(NBYTE - 1), "R3 wrap");
        read_word(w); check("R3 last byte", w, 16'(model[NBYTE - 1]));
        read_word(w); check("R3 wrapped to 0", w, 16'(model[0]));
        cs_lo();

        // R7: word mapping, 16-bit word n = {byte 2n, byte 2n+1}
        org = 1'b1;
        read_start(3, "R7 map");
        read_word(w); check("R7 word 3 from bytes", w, {model[6], model[7]});
        read_word(w); check("R7 word 4 from bytes", w, {model[8], model[9]});
        cs_lo();
        cmd(2'b01, 16'd10, 16'hA55A, 1); prog_wait("R7 write x16");
        model[20] = 8'hA5; model[21] = 8'h5A;
        read_start(16'(NBYTE / 2 - 1), "R7 x16 wrap");
        read_word(w); check("R7 x16 top word", w, {model[NBYTE - 2], model[NBYTE - 1]});
        read_word(w); check("R3 x16 wrap to 0", w, {model[0], model[1]});
        cs_lo();
        org = 1'b0;
        read_start(20, "R7 bytes");
        read_word(w); check("R7 high byte at even", w, 16'h00A5);
        read_word(w); check("R7 low byte at odd", w, 16'h005A);
        cs_lo();

        // R5: single-location erase
        cmd(2'b11, 16'd9, 0, 0); prog_wait("R5 erase");
        model[9] = 8'hFF;
        read_start(8, "R5 erase");
        read_word(w); check("R5 neighbour kept", w, 16'(model[8]));
        read_word(w); check("R5 erased to ones", w, 16'h00FF);
        cs_lo();

        // R11: start bit during busy is ignored, status stays on dout
        cmd(2'b01, 16'd4, 16'h66, 1); cs_lo(); cs_hi();
        bitx(1'b1);
        check("R11 start ignored while busy", {last_oe, last_do}, 2'b10);
        for (int n = 0; n < 300 && !(dout_oe && dout); n++) tick(1);
        check("R8 ready after start ignored", {dout_oe, dout}, 2'b11);
        bitx(1'b1); cs_lo();
        model[4] = 8'h66;

        // R9/R8/R10: cs low for whole cycle, status after, then cleared
        cmd(2'b01, 16'd7, 16'h5A, 1); cs_lo();
        tick(10);
        check("R9 oe low during cycle with cs low", dout_oe, 0);
        tick(PROG + 10);
        cs_hi();
        check("R8 ready seen after cycle", {dout_oe, dout}, 2'b11);
        bitx(1'b1); cs_lo(); cs_hi();
        check("R10 status cleared by start then cs low", dout_oe, 0);
        cs_lo();
        model[7] = 8'h5A;
        read_start(4, "R5 check");
        read_word(w); check("R11 byte 4 written", w, 16'h0066);
        read_word(w); check("R5 byte 5 untouched", w, 16'(model[5]));
        read_word(w); check("R5 byte 6 untouched", w, 16'(model[6]));
        read_word(w); check("R8 write finished with cs low", w, 16'h005A);
        cs_lo();

        // R11: bits after a complete enable frame are ignored
        cmd(2'b00, ext(2'b11), 0, 0);
        bitx(1'b1); send(16'b01, 2); send(16'd3, aw()); send(16'h00, dw());
        cs_lo(); cs_hi();
        check("R11 trailing frame started nothing", dout_oe, 0);
        cs_lo();
        read_start(3, "R11");
        read_word(w); check("R11 byte 3 unchanged", w, 16'(model[3]));
        cs_lo();

        // R6: fill-all with a 16-bit pattern, byte sweep
        org = 1'b1;
        cmd(2'b00, ext(2'b01), 16'h3CC3, 1); prog_wait("R6 fill-all");
        org = 1'b0;
        for (int a = 0; a < NBYTE; a++) model[a] = (a % 2 == 0) ? 8'h3C : 8'hC3;
        read_start(0, "R6 fill");
        for (int a = 0; a < NBYTE; a++) begin
            read_word(w);
            check($sformatf("R6 filled byte %0d", a), w, 16'(model[a]));
        end
        cs_lo();

        // R4: disable, then a write has no effect
        cmd(2'b00, ext(2'b00), 0, 0); cs_lo();
        cmd(2'b01, 16'd1, 16'h00, 1); cs_lo(); cs_hi();
        check("R4 write ignored when disabled, no status", dout_oe, 0);
        cs_lo();
        read_start(1, "R4");
        read_word(w); check("R4 byte 1 unchanged", w, 16'(model[1]));
        read_word(w);
        // R9: deselect mid-read releases dout
        cs_lo();
        check("R9 oe low after cs falls in read", dout_oe, 0);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule